// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a four-beat memory burst. A 17-bit starting address is captured whenever either of two active-low address-status strobes is asserted on a rising clock edge. After that, each clock edge with the active-low advance strobe asserted moves the two least significant address bits to the next beat. The upper 15 bits keep their captured value for the whole burst.

The beat order is chosen by a mode input, which is sampled together with the address. With mode low the order is linear: the two low bits count up by one and wrap from 3 back to 0. With mode high the order is interleaved: the low bits are the starting low bits XORed with a two-bit beat count. At the pad the mode pin carries a pull-up, so an unconnected pin reads high and selects interleaved order.

The outputs are the current full address and the two-bit beat count since the last load. Both come straight from registers and the two-bit adder or XOR that follows them.

Top module: `burst_seq`

## Requirements
- R1: While reset is sampled high, the next edge clears the address output and the beat count to 0.
- R2: When the first strobe (load_a_n = 0) is sampled, the next cycle shows addr_out equal to the sampled start_addr and beat_out equal to 0.
- R3: The second strobe (load_b_n = 0) loads in the same way as the first, and so does asserting both strobes together.
- R4: After a load with mode = 0, each sampled advance_n = 0 sets addr_out[1:0] to (start[1:0] + beat) mod 4, so the low bits count up and wrap from 3 to 0.
- R5: After a load with mode = 1, each sampled advance_n = 0 sets addr_out[1:0] to start[1:0] XOR beat. From starts 0, 1, 2 and 3 this gives 0-1-2-3, 1-0-3-2, 2-3-0-1 and 3-2-1-0.
- R6: Without a load, addr_out[16:2] keeps the loaded value, whatever happens on start_addr and advance_n.
- R7: With no strobe and advance_n = 1, addr_out and beat_out hold their values (the burst is suspended).
- R8: A load in the same cycle as an advance takes precedence: the new address is loaded with beat 0 and no step is taken.
- R9: mode is sampled only when a load is taken. Changing mode in the middle of a burst does not change the order of that burst.
- R10: beat_out counts advances modulo 4. After a fourth advance it returns to 0 and the burst keeps cycling through the same four addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | 17 | External start address |
| load_a_n | input | 1 | First address-status strobe, active low |
| load_b_n | input | 1 | Second address-status strobe, active low |
| advance_n | input | 1 | Burst advance strobe, active low |
| mode | input | 1 | Beat order: 1 interleaved (pull-up default), 0 linear |
| addr_out | output | 17 | Current burst address |
| beat_out | output | 2 | Beat count since the last load |

## Verification
A corrupted beat counter or captured start value shows up on addr_out[1:0] in the first cycle after the faulty edge, because the low bits are the start combined with the beat. A wrong captured mode stays hidden until the first advance with a start value whose sum and XOR differ, so the bench runs bursts from every start value in both orders. A fault in the upper bits, or a missed load priority, shows on the cycle after the load or the advance that triggers it. The bench checks the outputs against its own model every cycle so that none of these faults goes unseen.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 17,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              load_a_n,
  input  logic              load_b_n,
  input  logic              advance_n,
  input  logic              mode,
  output logic [ADDR_W-1:0] addr_out,
  output logic [LOW_W-1:0]  beat_out
);
  localparam int HI_W = ADDR_W - LOW_W;

  logic [HI_W-1:0]  hi_q;
  logic [LOW_W-1:0] start_q;
  logic [LOW_W-1:0] beat_q;
  logic             ilv_q;
  logic [LOW_W-1:0] low_bits;

  wire load = ~load_a_n | ~load_b_n;
  wire step = ~advance_n & ~load;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
      ilv_q   <= 1'b1;
    end else if (load) begin
      hi_q    <= start_addr[ADDR_W-1:LOW_W];
      start_q <= start_addr[LOW_W-1:0];
      beat_q  <= '0;
      ilv_q   <= mode;
    end else if (step) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign low_bits = ilv_q ? (start_q ^ beat_q) : (start_q + beat_q);
  assign addr_out = {hi_q, low_bits};
  assign beat_out = beat_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (addr_out == '0 && beat_out == '0));
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr_out == $past(start_addr) && beat_out == '0));
  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> addr_out[ADDR_W-1:LOW_W] == $past(addr_out[ADDR_W-1:LOW_W]));
  // R7
  suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && advance_n) |=> ($stable(addr_out) && $stable(beat_out)));
  // R10
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> beat_out == $past(beat_out) + 1'b1);
  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !ilv_q) |=> addr_out[LOW_W-1:0] == $past(addr_out[LOW_W-1:0]) + 1'b1);
  // R5
  ilv_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && ilv_q) |=> (addr_out[LOW_W-1:0] ^ beat_out) == $past(addr_out[LOW_W-1:0] ^ beat_out));
endmodule

// File: tb/burst_seq_test.sv
module burst_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] start_addr = '0;
  logic        load_a_n = 1'b1, load_b_n = 1'b1, advance_n = 1'b1, mode = 1'b1;
  logic [16:0] addr_out;
  logic [1:0]  beat_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [14:0] m_hi;
  logic [1:0]  m_start, m_beat;
  logic        m_ilv;

  burst_seq uut (.clk(clk), .rst(rst), .start_addr(start_addr), .load_a_n(load_a_n),
                 .load_b_n(load_b_n), .advance_n(advance_n), .mode(mode),
                 .addr_out(addr_out), .beat_out(beat_out));

  always #5 clk = ~clk;

  function automatic logic [16:0] exp_addr();
    logic [1:0] lo;
    lo = m_ilv ? (m_start ^ m_beat) : (m_start + m_beat);
    return {m_hi, lo};
  endfunction

  task automatic check(string tag);
    checks++;
    if (addr_out !== exp_addr() || beat_out !== m_beat) begin
      errors++;
      $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_out, beat_out, exp_addr(), m_beat);
    end
  endtask

  task automatic cyc(logic a_n, logic b_n, logic adv_n, logic md, logic [16:0] ad, string tag);
    @(negedge clk);
    load_a_n = a_n; load_b_n = b_n; advance_n = adv_n; mode = md; start_addr = ad;
    @(posedge clk);
    if (rst) begin
      m_hi = '0; m_start = '0; m_beat = '0; m_ilv = 1'b1;
    end else if (!a_n || !b_n) begin
      m_hi = ad[16:2]; m_start = ad[1:0]; m_beat = '0; m_ilv = md;
    end else if (!adv_n) begin
      m_beat = m_beat + 2'd1;
    end
    #2;
    check(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    cyc(1, 1, 1, 1, 17'h1ffff, "R1");
    cyc(0, 1, 0, 0, 17'h1abcd, "R1");
    rst = 1'b0;
    cyc(0, 1, 1, 0, 17'h12345, "R2");
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 17'h0ff00 + i, "R4 R10");
    cyc(1, 1, 1, 0, 17'h00000, "R7");
    cyc(1, 1, 1, 1, 17'h1ffff, "R6 R7");
    cyc(1, 1, 0, 1, 17'h0aaaa, "R9 R6");
    for (int s = 0; s < 4; s++) begin
      cyc(1, 0, 1, 1, {15'h4321, s[1:0]}, "R3");
      for (int i = 0; i < 4; i++) cyc(1, 1, 0, 1, 17'h0, "R5");
    end
    cyc(0, 0, 1, 0, 17'h0b7b7, "R3");
    cyc(1, 1, 0, 0, 17'h0, "R4");
    cyc(0, 1, 0, 1, 17'h0c00e, "R8");
    cyc(1, 0, 0, 0, 17'h00003, "R8");
    cyc(1, 1, 0, 1, 17'h0, "R9");
    cyc(1, 1, 0, 1, 17'h0, "R9");
    for (int i = 0; i < 3000; i++) begin
      logic a_n, b_n, adv_n;
      a_n   = ($urandom % 8) != 0;
      b_n   = ($urandom % 8) != 0;
      adv_n = ($urandom % 4) == 0;
      if (i == 1500) rst = 1'b1;
      if (i == 1502) rst = 1'b0;
      cyc(a_n, b_n, adv_n, 1'($urandom), 17'($urandom),
          rst ? "R1" : (!a_n || !b_n) ? "R2 R8" : adv_n ? "R7 R6" : "R4 R5 R10");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule